// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard (its clock and its data) into a fast system clock domain. It turns each serial frame the keyboard sends into one 8-bit scan code. The keyboard clock is treated as an asynchronous signal. Both lines pass through a two-flop synchronizer and a glitch filter, and one data bit is taken on each clean falling edge of the filtered keyboard clock.

Each accepted code sets a sticky ready flag. The flag stays set until the host pulses the read input, so the host sees every code exactly once. This holds for repeated make codes sent while a key is held down. It also holds for the two bytes of a release sequence: for example, the make code 1C is later followed by F0 and then 1C. The block does not interpret the codes and does not transmit to the keyboard.

Top module: `ps2_scan_rx`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ready` is 0 and `code` is 0. A partially received frame is dropped, so the next complete frame after reset is decoded correctly.
- R2: A frame is 11 bits, each taken on a falling edge of the filtered keyboard clock. The order is: start bit 0, then eight data bits with the least significant bit first, then a parity bit that makes the data plus parity count of ones odd, then a stop bit 1. The `code` output presents the eight data bits, with the first data bit received at bit 0.
- R3: After a valid frame completes, `ready` goes to 1. It stays at 1 for as long as `rd` is not pulsed.
- R4: When `rd` is high in a cycle with no completing frame, `ready` is 0 in the next cycle. A read leaves `code` unchanged.
- R5: A frame with a start bit of 1, a stop bit of 0, or even parity is discarded. `ready` and `code` both keep their previous values.
- R6: A level change on either keyboard line that lasts fewer than `FILTER_LEN` system clock cycles is ignored. A short low glitch on the keyboard clock inside a frame does not add a bit.
- R7: If a frame has started and no falling edge arrives for `IDLE_LIMIT` system clock cycles, the bit count returns to zero. The next frame is then received correctly.
- R8: A valid frame that completes while `ready` is already 1 replaces `code` with the new byte, and `ready` stays at 1. If a frame completes in the same cycle as `rd`, `ready` also stays at 1.
- R9: Every frame is its own ready event. Repeated make codes and each byte of a multi-byte release sequence are delivered one at a time, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kb_clk | input | 1 | Keyboard clock line, asynchronous |
| kb_data | input | 1 | Keyboard data line, asynchronous |
| rd | input | 1 | Read strobe, clears `ready` |
| code | output | 8 | Last accepted scan code |
| ready | output | 1 | Sticky flag: an unread code is waiting |

## Verification
The bench builds the receiver with `FILTER_LEN` = 3 and `IDLE_LIMIT` = 60 cycles, so one keyboard bit lasts only 20 system cycles. This small configuration makes a sweep over all 256 data values affordable, with the parity bit computed in the bench for each value. It also puts a 1-cycle clock glitch within reach of the filter, since that glitch is shorter than three cycles. Finally, a 100-cycle stall mid-frame is enough to exceed the idle limit. The read, overwrite, error-frame and release-sequence cases run in the same configuration.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  localparam int FRAME_BITS = 11;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // Bit order on the wire: start first, stop last.
  typedef struct packed {
    logic       stop;
    logic       par;
    logic [7:0] data;
    logic       start;
  } ps2_frame_t;

  function automatic logic frame_ok(ps2_frame_t f);
    return (!f.start) && f.stop && (^{f.data, f.par});
  endfunction

endpackage

// File: rtl/ps2_line_filt.sv
module ps2_line_filt #(
  parameter int FILTER_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILTER_LEN + 1);

  logic       s1, s2;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      run   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 != clean) begin
        if (run == CW'(FILTER_LEN - 1)) begin
          clean <= s2;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end

endmodule

// File: rtl/ps2_frame_shift.sv
module ps2_frame_shift
  import ps2_rx_pkg::*;
#(
  parameter int IDLE_LIMIT = 4800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             bit_in,
  output logic             done,
  output logic [7:0]       byte_out,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam int IW = $clog2(IDLE_LIMIT + 1);

  logic [FRAME_BITS-1:0] sh;
  logic [IW-1:0]         idle;
  ps2_frame_t            full;

  assign full = ps2_frame_t'({bit_in, sh[FRAME_BITS-1:1]});

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      idle     <= '0;
      bit_cnt  <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      done <= 1'b0;
      if (fall) begin
        idle <= '0;
        sh   <= {bit_in, sh[FRAME_BITS-1:1]};
        if (bit_cnt == CNT_W'(FRAME_BITS - 1)) begin
          bit_cnt  <= '0;
          done     <= frame_ok(full);
          byte_out <= full.data;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0) begin
        if (idle == IW'(IDLE_LIMIT - 1)) begin
          idle    <= '0;
          bit_cnt <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else begin
        idle <= '0;
      end
    end
  end

endmodule

// File: rtl/ps2_code_hold.sv
module ps2_code_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       done,
  input  logic [7:0] byte_in,
  input  logic       rd,
  output logic [7:0] code,
  output logic       ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      ready <= 1'b0;
    end else if (done) begin
      code  <= byte_in;
      ready <= 1'b1;
    end else if (rd) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx
  import ps2_rx_pkg::*;
#(
  parameter int FILTER_LEN = 8,
  parameter int IDLE_LIMIT = 4800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kb_clk,
  input  logic       kb_data,
  input  logic       rd,
  output logic [7:0] code,
  output logic       ready
);
  logic             clk_f, data_f, clk_q, fall;
  logic             fr_done;
  logic [7:0]       fr_byte;
  logic [CNT_W-1:0] fr_cnt;

  ps2_line_filt #(.FILTER_LEN(FILTER_LEN)) u_fclk (
    .clk(clk), .rst(rst), .raw(kb_clk), .clean(clk_f));
  ps2_line_filt #(.FILTER_LEN(FILTER_LEN)) u_fdat (
    .clk(clk), .rst(rst), .raw(kb_data), .clean(data_f));

  always_ff @(posedge clk) begin
    if (rst) clk_q <= 1'b1;
    else     clk_q <= clk_f;
  end
  assign fall = clk_q & ~clk_f;

  ps2_frame_shift #(.IDLE_LIMIT(IDLE_LIMIT)) u_shift (
    .clk(clk), .rst(rst), .fall(fall), .bit_in(data_f),
    .done(fr_done), .byte_out(fr_byte), .bit_cnt(fr_cnt));

  ps2_code_hold u_hold (
    .clk(clk), .rst(rst), .done(fr_done), .byte_in(fr_byte),
    .rd(rd), .code(code), .ready(ready));

endmodule

// File: rtl/ps2_scan_rx_chk.sv
module ps2_scan_rx_chk
  import ps2_rx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rd,
  input logic [7:0]       code,
  input logic             ready,
  input logic             fr_done,
  input logic [7:0]       fr_byte,
  input logic [CNT_W-1:0] fr_cnt
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!ready && code == 8'h00));
  // R3
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && !rd) |=> ready);
  // R3
  p_ready_source_r3: assert property (@(posedge clk) disable iff (rst)
    (!ready && !fr_done) |=> !ready);
  // R4
  p_rd_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && !fr_done) |=> !ready);
  // R8
  p_load_r8: assert property (@(posedge clk) disable iff (rst)
    fr_done |=> (ready && code == $past(fr_byte)));
  // R5
  p_code_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !fr_done |=> $stable(code));
  // R2
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    fr_cnt < CNT_W'(FRAME_BITS));
endmodule

bind ps2_scan_rx ps2_scan_rx_chk u_chk (
  .clk(clk), .rst(rst), .rd(rd), .code(code), .ready(ready),
  .fr_done(fr_done), .fr_byte(fr_byte), .fr_cnt(fr_cnt));

// File: tb/ps2_scan_rx_test.sv
module ps2_scan_rx_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kb_clk = 1'b1;
  logic       kb_data = 1'b1;
  logic       rd = 1'b0;
  logic [7:0] code;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  ps2_scan_rx #(.FILTER_LEN(3), .IDLE_LIMIT(60)) uut (
    .clk(clk), .rst(rst), .kb_clk(kb_clk), .kb_data(kb_data),
    .rd(rd), .code(code), .ready(ready));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    kb_data = b;
    idle(5);
    kb_clk = 1'b0;
    idle(10);
    kb_clk = 1'b1;
    idle(5);
  endtask

  // kind: 0 good, 1 bad parity, 2 bad start, 3 bad stop, 4 glitch mid-frame
  task automatic send_frame(input logic [7:0] b, input int kind);
    logic [10:0] f;
    f = {1'b1, ~^b, b, 1'b0};
    if (kind == 1) f[9]  = ~f[9];
    if (kind == 2) f[0]  = 1'b1;
    if (kind == 3) f[10] = 1'b0;
    for (int i = 0; i < 11; i++) begin
      send_bit(f[i]);
      if (kind == 4 && i == 4) begin
        kb_clk = 1'b0; idle(1); kb_clk = 1'b1; idle(1);
        kb_data = 1'b0; idle(2); kb_data = 1'b1; idle(4);
      end
    end
    kb_data = 1'b1;
    idle(20);
  endtask

  task automatic do_read();
    rd = 1'b1; idle(1); rd = 1'b0;
  endtask

  task automatic expect_code(input logic [7:0] b, input string tag);
    chk(ready === 1'b1, {tag, " ready"}, ready, 1);
    chk(code === b, {tag, " code"}, code, b);
    do_read();
    chk(ready === 1'b0, "R4 ready after read", ready, 0);
    chk(code === b, "R4 code kept on read", code, b);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    idle(4);
    chk(ready === 1'b0, "R1 reset ready", ready, 0);
    chk(code === 8'h00, "R1 reset code", code, 0);
    rst = 1'b0;
    idle(2);

    // R2 / R3: sweep of every data value
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 0);
      chk(ready === 1'b1, "R3 ready after frame", ready, 1);
      idle(7);
      chk(ready === 1'b1, "R3 ready held", ready, 1);
      chk(code === 8'(v), "R2 code value", code, v);
      do_read();
      chk(ready === 1'b0, "R4 ready after read", ready, 0);
    end

    // R5: corrupted frames
    send_frame(8'h5A, 0);
    do_read();
    for (int k = 1; k <= 3; k++) begin
      send_frame(8'hA3, k);
      chk(ready === 1'b0, "R5 bad frame ready", ready, 0);
      chk(code === 8'h5A, "R5 bad frame code", code, 8'h5A);
    end
    send_frame(8'h33, 0);
    expect_code(8'h33, "R5 recovery");

    // R6: short glitches inside a frame
    send_frame(8'hC6, 4);
    expect_code(8'hC6, "R6 glitch");

    // R7: stalled partial frame
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    idle(100);
    chk(ready === 1'b0, "R7 no event on stall", ready, 0);
    send_frame(8'h71, 0);
    expect_code(8'h71, "R7 after stall");

    // R8: overwrite while unread
    send_frame(8'h11, 0);
    send_frame(8'h22, 0);
    expect_code(8'h22, "R8 overwrite");

    // R9: held key repeats then release sequence
    for (int i = 0; i < 3; i++) begin
      send_frame(8'h1C, 0);
      expect_code(8'h1C, "R9 repeat");
    end
    send_frame(8'hF0, 0);
    expect_code(8'hF0, "R9 break prefix");
    send_frame(8'h1C, 0);
    expect_code(8'h1C, "R9 break code");

    // R1: reset during a partial frame
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    rst = 1'b1;
    idle(3);
    chk(ready === 1'b0, "R1 reset mid ready", ready, 0);
    chk(code === 8'h00, "R1 reset mid code", code, 0);
    rst = 1'b0;
    idle(3);
    send_frame(8'h9E, 0);
    expect_code(8'h9E, "R1 after reset");

    finish_run();
  end
endmodule